// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and presents them to a processor as two request lines: a normal line and a fast line. Each source can also be raised by software through a force register. A per-source enable bit gates the source. A per-source type bit then sends it either to the normal path or to the fast path.

On the normal path each source carries a 4-bit priority. A software-set level mask can hide low-priority sources. A resolver picks one winner and reports its number and priority through a read-only vector word. The interrupt handler reads this word until it returns all ones. On the fast path the vector word names the highest-numbered pending fast source.

Software reaches everything through a simple 32-bit register port. A write is taken on the clock edge when `bus_wr` is high. A read is combinational from `bus_addr`. Single sources can be enabled or disabled by writing their number, without a read-modify-write of the enable words.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, control (0x00) reads 0 and the level mask (0x04) reads 0x1F. Enables, types, forces and priorities read 0. The normal vector (0x40) reads 0xFFFFFFFF and the fast vector (0x44) reads 0xFFFF0000. Unmapped offsets read 0.
- R2: Normal pending is (source OR force) AND enable AND NOT type. Fast pending is the same term with type instead of NOT type. Each 64-bit register has its upper word (sources 32–63) at the lower offset: enable 0x10/0x14, type 0x18/0x1C, raw source 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C and fast pending 0x60/0x64. Normal pending is not affected by the level mask.
- R3: The priority of source n sits in bits [4*(n%8)+3 : 4*(n%8)] of the priority word at offset 0x20 + 4*(7 − n/8). So sources 56–63 are at 0x20 and sources 0–7 are at 0x3C.
- R4: The normal vector holds the winning source number in bits [31:16] and its priority in bits [15:0]. The winner has the highest priority. On a tie the higher source number wins. With no eligible source the normal vector reads 0xFFFFFFFF.
- R5: The level mask is a 5-bit field. The value 0x1F turns masking off. Any other value makes a normal source eligible only if its priority is strictly greater than the mask.
- R6: The fast vector holds the highest-numbered fast-pending source in bits [31:16] and zero in bits [15:0]. It reads 0xFFFF0000 when no source is fast-pending. `fast_req` is high exactly when any source is fast-pending.
- R7: Writing a value v < 64 to 0x08 sets enable bit v, and writing it to 0x0C clears enable bit v. Values of 64 or more leave all enables unchanged. Both offsets read 0.
- R8: `norm_req` is high exactly when some normal-pending source is eligible under the level mask, which is also when the normal vector is not 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 64 | Level-sensitive interrupt sources |
| norm_req | output | 1 | Normal interrupt request |
| fast_req | output | 1 | Fast interrupt request |

## Verification
The bench targets the corner cases that are easy to get wrong:
- **Priority ties.** A resolver that favours the lower number on a tie returns the wrong vector.
- **Reversed priority-word order.** Bank order that is not reversed assigns sources 0–7 the priority written for 56–63.
- **Level-mask boundary.** A source whose priority equals the mask must be suppressed. An off-by-one comparison would let it raise `norm_req`.
- **Mask value 0x1F.** This value must disable masking, not hide every source.
- **Out-of-range numbers.** Writing 64 or above to enable-by-number or disable-by-number must change nothing. Truncating the value to six bits would flip enable 0.
- **Type routing.** A fast-typed source must never appear in the normal vector.

Random register traffic checks all of these against a bench model.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int unsigned ADDR_W = 7;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t OFS_CTRL   = 7'h00;
   localparam addr_t OFS_LEVEL  = 7'h04;
   localparam addr_t OFS_SETNUM = 7'h08;
   localparam addr_t OFS_CLRNUM = 7'h0C;
   localparam addr_t OFS_ENA_HI = 7'h10;
   localparam addr_t OFS_ENA_LO = 7'h14;
   localparam addr_t OFS_TYP_HI = 7'h18;
   localparam addr_t OFS_TYP_LO = 7'h1C;
   localparam addr_t OFS_NVEC   = 7'h40;
   localparam addr_t OFS_FVEC   = 7'h44;
   localparam addr_t OFS_RAW_HI = 7'h48;
   localparam addr_t OFS_RAW_LO = 7'h4C;
   localparam addr_t OFS_FRC_HI = 7'h50;
   localparam addr_t OFS_FRC_LO = 7'h54;
   localparam addr_t OFS_NPD_HI = 7'h58;
   localparam addr_t OFS_NPD_LO = 7'h5C;
   localparam addr_t OFS_FPD_HI = 7'h60;
   localparam addr_t OFS_FPD_LO = 7'h64;

   localparam logic [4:0] LEVEL_OFF = 5'h1F;
endpackage

// File: rtl/ivc_pend.sv
// Per-source gating: builds the normal and fast pending vectors and applies
// the level mask to the normal path.
module ivc_pend #(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned PRIO_W = 4
) (
   input  logic [N_SRC-1:0]        src,
   input  logic [N_SRC-1:0]        frc,
   input  logic [N_SRC-1:0]        ena,
   input  logic [N_SRC-1:0]        typ,
   input  logic [N_SRC*PRIO_W-1:0] prio,
   input  logic [4:0]              level,
   output logic [N_SRC-1:0]        npend,
   output logic [N_SRC-1:0]        fpend,
   output logic [N_SRC-1:0]        elig
);
   import ivc_pkg::*;

   logic mask_off;
   assign mask_off = (level == LEVEL_OFF);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic active;
      assign active   = (src[i] | frc[i]) & ena[i];
      assign npend[i] = active & ~typ[i];
      assign fpend[i] = active &  typ[i];
      assign elig[i]  = npend[i] &
                        (mask_off | (5'(prio[i*PRIO_W +: PRIO_W]) > level));
   end
endmodule

// File: rtl/ivc_pick.sv
// Linear resolver: the highest priority wins, and a later index wins a tie.
module ivc_pick #(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned IW    = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]        cand,
   input  logic [N_SRC*PRIO_W-1:0] prio,
   output logic                    found,
   output logic [IW-1:0]           idx,
   output logic [PRIO_W-1:0]       level
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      level = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] >= level)) begin
            found = 1'b1;
            idx   = IW'(i);
            level = prio[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned PRIO_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [6:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [N_SRC-1:0] src_in,
   output logic             norm_req,
   output logic             fast_req
);
   import ivc_pkg::*;

   localparam int unsigned IW    = $clog2(N_SRC);
   localparam int unsigned HALF  = N_SRC / 2;
   localparam int unsigned PW_BITS = N_SRC * PRIO_W;

   if (N_SRC != 64 || PRIO_W != 4) begin : g_param_check
      $error("irq_vector_ctrl: register map needs N_SRC=64 and PRIO_W=4");
   end

   logic [31:0]        ctrl_q;
   logic [4:0]         lvl_q;
   logic [N_SRC-1:0]   en_q, ty_q, frc_q;
   logic [PW_BITS-1:0] prio_q;

   logic [N_SRC-1:0]   npend, fpend, elig;
   logic               nfound, ffound;
   logic [IW-1:0]      nidx, fidx;
   logic [PRIO_W-1:0]  nprio, fprio;
   logic [31:0]        nvec, fvec;

   // priority words sit in reverse order: offset 0x20 holds the top bank
   logic        is_prio;
   logic [2:0]  pbank;
   logic        num_ok;
   assign is_prio = (bus_addr[6:5] == 2'b01) && (bus_addr[1:0] == 2'b00);
   assign pbank   = ~bus_addr[4:2];
   assign num_ok  = (bus_wdata < 32'(N_SRC));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         lvl_q  <= LEVEL_OFF;
         en_q   <= '0;
         ty_q   <= '0;
         frc_q  <= '0;
         prio_q <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            OFS_CTRL:   ctrl_q <= bus_wdata;
            OFS_LEVEL:  lvl_q  <= bus_wdata[4:0];
            OFS_SETNUM: if (num_ok) en_q[bus_wdata[IW-1:0]] <= 1'b1;
            OFS_CLRNUM: if (num_ok) en_q[bus_wdata[IW-1:0]] <= 1'b0;
            OFS_ENA_HI: en_q[N_SRC-1:HALF]  <= bus_wdata;
            OFS_ENA_LO: en_q[HALF-1:0]      <= bus_wdata;
            OFS_TYP_HI: ty_q[N_SRC-1:HALF]  <= bus_wdata;
            OFS_TYP_LO: ty_q[HALF-1:0]      <= bus_wdata;
            OFS_FRC_HI: frc_q[N_SRC-1:HALF] <= bus_wdata;
            OFS_FRC_LO: frc_q[HALF-1:0]     <= bus_wdata;
            default: if (is_prio) prio_q[32*int'(pbank) +: 32] <= bus_wdata;
         endcase
      end
   end

   ivc_pend #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pend (
      .src(src_in), .frc(frc_q), .ena(en_q), .typ(ty_q),
      .prio(prio_q), .level(lvl_q),
      .npend(npend), .fpend(fpend), .elig(elig)
   );

   ivc_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_norm_pick (
      .cand(elig), .prio(prio_q),
      .found(nfound), .idx(nidx), .level(nprio)
   );

   // fast path: equal priorities, so the highest number wins
   ivc_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_fast_pick (
      .cand(fpend), .prio({PW_BITS{1'b0}}),
      .found(ffound), .idx(fidx), .level(fprio)
   );

   assign nvec = nfound ? {16'(nidx), 16'(nprio)} : 32'hFFFF_FFFF;
   assign fvec = ffound ? {16'(fidx), 16'(fprio)} : 32'hFFFF_0000;

   assign norm_req = nfound;
   assign fast_req = ffound;

   always_comb begin
      case (bus_addr)
         OFS_CTRL:   bus_rdata = ctrl_q;
         OFS_LEVEL:  bus_rdata = {27'd0, lvl_q};
         OFS_ENA_HI: bus_rdata = en_q[N_SRC-1:HALF];
         OFS_ENA_LO: bus_rdata = en_q[HALF-1:0];
         OFS_TYP_HI: bus_rdata = ty_q[N_SRC-1:HALF];
         OFS_TYP_LO: bus_rdata = ty_q[HALF-1:0];
         OFS_NVEC:   bus_rdata = nvec;
         OFS_FVEC:   bus_rdata = fvec;
         OFS_RAW_HI: bus_rdata = src_in[N_SRC-1:HALF];
         OFS_RAW_LO: bus_rdata = src_in[HALF-1:0];
         OFS_FRC_HI: bus_rdata = frc_q[N_SRC-1:HALF];
         OFS_FRC_LO: bus_rdata = frc_q[HALF-1:0];
         OFS_NPD_HI: bus_rdata = npend[N_SRC-1:HALF];
         OFS_NPD_LO: bus_rdata = npend[HALF-1:0];
         OFS_FPD_HI: bus_rdata = fpend[N_SRC-1:HALF];
         OFS_FPD_LO: bus_rdata = fpend[HALF-1:0];
         default:    bus_rdata = is_prio ? prio_q[32*int'(pbank) +: 32] : 32'd0;
      endcase
   end
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned IW    = $clog2(N_SRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [6:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [N_SRC-1:0]  src_in,
   input logic [N_SRC-1:0]  en_q,
   input logic [N_SRC-1:0]  ty_q,
   input logic [N_SRC-1:0]  frc_q,
   input logic [4:0]        lvl_q,
   input logic [PRIO_W-1:0] nprio,
   input logic              norm_req,
   input logic              fast_req
);
   logic [N_SRC-1:0] live;
   assign live = (src_in | frc_q) & en_q;

   // R7: enable-by-number sets the named bit
   p_setnum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 7'h08 && bus_wdata < 32'(N_SRC))
      |=> en_q[$past(bus_wdata[IW-1:0])]);

   // R7: disable-by-number clears the named bit
   p_clrnum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 7'h0C && bus_wdata < 32'(N_SRC))
      |=> !en_q[$past(bus_wdata[IW-1:0])]);

   // R7: out-of-range numbers leave the enables alone
   p_num_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == 7'h08 || bus_addr == 7'h0C) && bus_wdata >= 32'(N_SRC))
      |=> $stable(en_q));

   // R8: a normal request needs a live normal-typed source
   p_norm_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      norm_req |-> |(live & ~ty_q));

   // R6: the fast request follows the live fast-typed sources
   p_fast_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fast_req == |(live & ty_q));

   // R5: with masking on, the winning priority lies above the mask
   p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_req && lvl_q != 5'h1F) |-> (5'(nprio) > lvl_q));
endmodule

bind irq_vector_ctrl ivc_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .src_in(src_in), .en_q(en_q), .ty_q(ty_q),
   .frc_q(frc_q), .lvl_q(lvl_q), .nprio(nprio),
   .norm_req(norm_req), .fast_req(fast_req)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_in = '0;
   logic        norm_req, fast_req;

   always #5 clk = ~clk;

   irq_vector_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
      .norm_req(norm_req), .fast_req(fast_req)
   );

   int total = 0, bad = 0;
   bit ended = 0;

   // bench model of the software-visible state
   logic [31:0] m_ctrl;
   logic [4:0]  m_lvl;
   logic [63:0] m_en, m_ty, m_frc;
   logic [3:0]  m_pr [64];

   task automatic model_reset();
      m_ctrl = 0; m_lvl = 5'h1F; m_en = 0; m_ty = 0; m_frc = 0;
      for (int i = 0; i < 64; i++) m_pr[i] = 0;
   endtask

   function automatic logic [63:0] m_np();
      return (src_in | m_frc) & m_en & ~m_ty;
   endfunction
   function automatic logic [63:0] m_fp();
      return (src_in | m_frc) & m_en & m_ty;
   endfunction

   function automatic logic [31:0] m_nvec();
      logic [63:0] np = m_np();
      int win = -1;
      for (int i = 0; i < 64; i++)
         if (np[i] && (m_lvl == 5'h1F || {1'b0, m_pr[i]} > m_lvl))
            if (win < 0 || m_pr[i] >= m_pr[win]) win = i;
      if (win < 0) return 32'hFFFF_FFFF;
      return {16'(win), 12'd0, m_pr[win]};
   endfunction

   function automatic logic [31:0] m_fvec();
      logic [63:0] fp = m_fp();
      for (int i = 63; i >= 0; i--) if (fp[i]) return {16'(i), 16'd0};
      return 32'hFFFF_0000;
   endfunction

   function automatic logic [31:0] m_read(logic [6:0] a);
      logic [31:0] w;
      if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 0) begin
         int k = 7 - int'((a - 7'h20) >> 2);
         w = 0;
         for (int j = 0; j < 8; j++) w[4*j +: 4] = m_pr[8*k + j];
         return w;
      end
      case (a)
         7'h00: return m_ctrl;
         7'h04: return {27'd0, m_lvl};
         7'h10: return m_en[63:32];  7'h14: return m_en[31:0];
         7'h18: return m_ty[63:32];  7'h1C: return m_ty[31:0];
         7'h40: return m_nvec();     7'h44: return m_fvec();
         7'h48: return src_in[63:32]; 7'h4C: return src_in[31:0];
         7'h50: return m_frc[63:32]; 7'h54: return m_frc[31:0];
         7'h58: begin w = m_np(); return w; end
         7'h5C: begin w = m_np(); return w; end
         default: ;
      endcase
      if (a == 7'h58) return m_np() >> 32;
      if (a == 7'h60) return 32'(m_fp() >> 32);
      if (a == 7'h64) return 32'(m_fp());
      return 0;
   endfunction

   function automatic logic [31:0] m_read_fix(logic [6:0] a);
      if (a == 7'h58) return 32'(m_np() >> 32);
      if (a == 7'h5C) return 32'(m_np());
      return m_read(a);
   endfunction

   function automatic string tag_of(logic [6:0] a);
      if (a == 7'h40) return "R4";
      if (a == 7'h44) return "R6";
      if (a >= 7'h48) return "R2";
      if (a >= 7'h20) return "R3";
      if (a == 7'h04) return "R5";
      if (a == 7'h08 || a == 7'h0C) return "R7";
      if (a >= 7'h10) return "R2";
      return "R1";
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [6:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         7'h00: m_ctrl = d;
         7'h04: m_lvl = d[4:0];
         7'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
         7'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
         7'h10: m_en[63:32] = d;  7'h14: m_en[31:0] = d;
         7'h18: m_ty[63:32] = d;  7'h1C: m_ty[31:0] = d;
         7'h50: m_frc[63:32] = d; 7'h54: m_frc[31:0] = d;
         default:
            if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 0) begin
               int k = 7 - int'((a - 7'h20) >> 2);
               for (int j = 0; j < 8; j++) m_pr[8*k + j] = d[4*j +: 4];
            end
      endcase
   endtask

   task automatic rd_chk(logic [6:0] a);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag_of(a), bus_rdata, m_read_fix(a));
   endtask

   task automatic rd_const(string tag, logic [6:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic chk_lines();
      #1;
      chk("R8", 32'(norm_req), 32'(m_nvec() != 32'hFFFF_FFFF));
      chk("R6", 32'(fast_req), 32'(m_fp() != 0));
   endtask

   task automatic sweep();
      rd_chk(7'h40); rd_chk(7'h44);
      rd_chk(7'h58); rd_chk(7'h5C); rd_chk(7'h60); rd_chk(7'h64);
      chk_lines();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         bad++; total++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_const("R1", 7'h00, 32'h0);
      rd_const("R1", 7'h04, 32'h1F);
      rd_const("R1", 7'h40, 32'hFFFF_FFFF);
      rd_const("R1", 7'h44, 32'hFFFF_0000);
      rd_const("R1", 7'h3C, 32'h0);
      rd_const("R1", 7'h14, 32'h0);
      rd_const("R1", 7'h70, 32'h0);
      chk("R1", 32'(norm_req), 32'h0);

      // R3 reversed bank order: sources 56/57 live in the word at 0x20
      wr(7'h10, 32'hFFFF_FFFF);
      src_in = 64'h0300_0000_0000_0000;
      wr(7'h20, 32'h0000_0035);
      rd_const("R3", 7'h40, 32'h0038_0005);
      rd_const("R3", 7'h3C, 32'h0);

      // R4 tie: equal priorities, higher number wins
      src_in = 64'h0000_0000_0000_0208;
      wr(7'h14, 32'hFFFF_FFFF);
      rd_const("R4", 7'h40, 32'h0009_0000);

      // R5 mask boundary: priority equal to the mask is suppressed
      src_in = 64'h0100_0000_0000_0000;
      wr(7'h04, 32'd5);
      rd_const("R5", 7'h40, 32'hFFFF_FFFF);
      chk("R8", 32'(norm_req), 32'h0);
      rd_const("R2", 7'h58, 32'h0100_0000);
      wr(7'h04, 32'd4);
      rd_const("R5", 7'h40, 32'h0038_0005);
      wr(7'h04, 32'h1F);

      // R7 numbered enable/disable, including out-of-range values
      wr(7'h0C, 32'd56);
      rd_const("R7", 7'h10, 32'hFEFF_FFFF);
      wr(7'h0C, 32'd64);
      wr(7'h08, 32'd100);
      rd_const("R7", 7'h10, 32'hFEFF_FFFF);
      rd_const("R7", 7'h14, 32'hFFFF_FFFF);
      wr(7'h08, 32'd56);
      rd_const("R7", 7'h10, 32'hFFFF_FFFF);
      rd_const("R7", 7'h08, 32'h0);

      // R6 fast routing takes the source off the normal path
      wr(7'h18, 32'h0100_0000);
      rd_const("R6", 7'h44, 32'h0038_0000);
      rd_const("R6", 7'h40, 32'hFFFF_FFFF);
      sweep();

      // random register traffic
      for (int it = 0; it < 400; it++) begin
         int sel = $urandom_range(0, 9);
         logic [31:0] d = $urandom;
         case (sel)
            0: wr(7'h04, ($urandom_range(0, 1) != 0) ? 32'h1F : 32'($urandom_range(0, 15)));
            1: wr(7'h08, 32'($urandom_range(0, 70)));
            2: wr(7'h0C, 32'($urandom_range(0, 70)));
            3: wr(($urandom_range(0, 1) != 0) ? 7'h10 : 7'h14, d);
            4: wr(($urandom_range(0, 1) != 0) ? 7'h18 : 7'h1C, d & $urandom);
            5, 6: wr(7'(7'h20 + 4 * $urandom_range(0, 7)), d);
            7: wr(($urandom_range(0, 1) != 0) ? 7'h50 : 7'h54, d & $urandom & $urandom);
            8: wr(7'h00, d);
            default: ;
         endcase
         @(negedge clk);
         src_in = {$urandom, $urandom} & {$urandom, $urandom};
         sweep();
         if (it % 8 == 0) rd_chk(7'(7'h20 + 4 * $urandom_range(0, 7)));
         if (it % 16 == 0) begin rd_chk(7'h04); rd_chk(7'h10); rd_chk(7'h00); end
      end

      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule